// File: doc/BRIEF.md
# Glitch-Free Core Clock Source Selector

This block produces the two clocks delivered to the user area of a chip. It takes an external reference clock and two quadrature outputs of an on-chip oscillator, one at 0 degrees and one at 90 degrees. Each oscillator phase goes through its own integer divider, programmable from 1 to 7. The 90-degree phase, once divided, is the primary clock. The 0-degree phase, once divided, is the secondary user clock.

The core clock output is taken either from the external clock or from the divided 90-degree clock. The choice is made by a bypass bit. The switch between the two sources hands over without runt pulses. An enable bit stops and restarts both oscillator-derived clocks. When they stop, they always stop low and at a period boundary.

Register bits arrive as quasi-static levels. Each clock domain has its own reset, which asserts asynchronously and releases synchronously.

Top module: `clk_src_sel`

## Requirements
- R1: With bypass_i = 1, core_clk_o reproduces ext_clk_i (same period and high time) once the switch has settled.
- R2: core_clk_o never shows a high or low pulse shorter than half the period of the faster of its two sources, including across bypass changes; the two source gates are never both open.
- R3: With bypass_i = 0 and enable_i = 1, core_clk_o has period N times the osc_p90_clk_i period and a high time of exactly N half periods, where N = core_div_i for values 1 to 7 (odd ratios included).
- R4: user_clk_o has period M times the osc_p0_clk_i period and a high time of exactly M half periods, where M = user_div_i for values 1 to 7.
- R5: A divide field of value 0 behaves as divide-by-1 on either output.
- R6: A new divide value is taken only when the running divided period ends, so a change never shortens a pulse on either output.
- R7: With enable_i = 0, both divided clocks finish their current period and then stay low, so core_clk_o is held low while bypass_i = 0. Setting enable_i back to 1 restarts them at the programmed ratios.
- R8: Setting bypass_i = 1 while the divided clocks are stopped still hands core_clk_o over to ext_clk_i.
- R9: While rst_ni is low, both core_clk_o and user_clk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset, synchronised per clock domain |
| ext_clk_i | input | 1 | External reference clock |
| osc_p0_clk_i | input | 1 | Oscillator output, 0-degree phase |
| osc_p90_clk_i | input | 1 | Oscillator output, 90-degree phase |
| bypass_i | input | 1 | 1: core clock from ext_clk_i; 0: from the divided 90-degree clock |
| enable_i | input | 1 | 1: divided oscillator clocks run; 0: they stop low |
| core_div_i | input | 3 | Divide ratio for the 90-degree phase (0 treated as 1) |
| user_div_i | input | 3 | Divide ratio for the 0-degree phase (0 treated as 1) |
| core_clk_o | output | 1 | Selected core clock |
| user_clk_o | output | 1 | Divided 0-degree clock for the user area |

## Verification
Some properties are checked by assertions on every cycle:
- the two source gates of the switch are never open together;
- the divider counter stays inside its ratio;
- a divider loads a new ratio only on its last count;
- a stopped divider holds its output low.

Other properties can only be shown by the bench's scenarios, which time the output edges against the oscillator periods:
- the actual periods and high times for every ratio from 0 to 7;
- the absence of short pulses across ratio changes and source hand-overs;
- the stop and restart behaviour of the enable bit;
- the hand-over to the external clock while the oscillator-derived clock is stopped.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned DIV_W_DEF  = 3;
  localparam int unsigned SYNC_N_DEF = 2;
endpackage

// File: rtl/clk_rst_sync.sv
module clk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/clk_int_div.sv
module clk_int_div #(
  parameter int unsigned W    = 3,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         clk_o,
  output logic         idle_o
);
  logic [SYNC-1:0] en_sync_q;
  logic [W-1:0]    ratio_new, r_q, cnt_q, cnt_inc;
  logic            run_q, rise_q, fall_q, en_s, last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_sync_q <= '0;
    else         en_sync_q <= {en_sync_q[SYNC-2:0], en_i};
  end

  assign en_s      = en_sync_q[SYNC-1];
  assign ratio_new = (ratio_i == '0) ? W'(1) : ratio_i;
  assign cnt_inc   = cnt_q + 1'b1;
  assign last      = (cnt_q == r_q - 1'b1);

  // Output = rise_q ^ fall_q: each edge comes from exactly one flop toggle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      r_q    <= W'(1);
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else if (!run_q) begin
      if (en_s) begin
        run_q  <= 1'b1;
        r_q    <= ratio_new;
        cnt_q  <= '0;
        rise_q <= ~rise_q;
      end
    end else if (last) begin
      cnt_q <= '0;
      if (en_s) begin
        r_q    <= ratio_new;
        rise_q <= ~rise_q;
      end else begin
        run_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_inc;
      if (!r_q[0] && (cnt_inc == (r_q >> 1))) rise_q <= ~rise_q;
    end
  end

  // Odd ratios fall mid-cycle.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else if (run_q && r_q[0] && (cnt_q == (r_q >> 1))) fall_q <= ~fall_q;
  end

  assign clk_o  = rise_q ^ fall_q;
  assign idle_o = ~run_q;

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !last) |=> $stable(r_q)); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < r_q)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_o); // R7
endmodule

// File: rtl/clk_glitch_free_mux.sv
module clk_glitch_free_mux (
  input  logic clk_a_i,
  input  logic rst_a_ni,
  input  logic clk_b_i,
  input  logic rst_b_ni,
  input  logic sel_b_i,
  input  logic b_idle_i,
  output logic clk_o
);
  logic s_a_q, en_a_q, s_b_q, en_b_q, clr_b_n;

  // B side may be dropped asynchronously only while its clock is parked low.
  assign clr_b_n = rst_b_ni & ~(b_idle_i & ~sel_b_i);

  always_ff @(posedge clk_a_i or negedge rst_a_ni) begin
    if (!rst_a_ni) s_a_q <= 1'b0;
    else           s_a_q <= ~sel_b_i & ~en_b_q;
  end

  always_ff @(negedge clk_a_i or negedge rst_a_ni) begin
    if (!rst_a_ni) en_a_q <= 1'b0;
    else           en_a_q <= s_a_q & ~sel_b_i & ~en_b_q;
  end

  always_ff @(posedge clk_b_i or negedge clr_b_n) begin
    if (!clr_b_n) s_b_q <= 1'b0;
    else          s_b_q <= sel_b_i & ~en_a_q;
  end

  always_ff @(negedge clk_b_i or negedge clr_b_n) begin
    if (!clr_b_n) en_b_q <= 1'b0;
    else          en_b_q <= s_b_q & sel_b_i & ~en_a_q;
  end

  assign clk_o = (clk_a_i & en_a_q) | (clk_b_i & en_b_q);

  AST_EXCL_GATE: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    !(en_a_q && en_b_q)); // R2
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_src_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             osc_p0_clk_i,
  input  logic             osc_p90_clk_i,
  input  logic             bypass_i,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] core_div_i,
  input  logic [DIV_W-1:0] user_div_i,
  output logic             core_clk_o,
  output logic             user_clk_o
);
  logic rst_ext_n, rst_p0_n, rst_p90_n;
  logic prim_clk, prim_idle, user_idle;

  clk_rst_sync #(.STAGES(SYNC_N)) u_rst_ext (.clk_i(ext_clk_i),     .rst_ni(rst_ni), .rst_no(rst_ext_n));
  clk_rst_sync #(.STAGES(SYNC_N)) u_rst_p0  (.clk_i(osc_p0_clk_i),  .rst_ni(rst_ni), .rst_no(rst_p0_n));
  clk_rst_sync #(.STAGES(SYNC_N)) u_rst_p90 (.clk_i(osc_p90_clk_i), .rst_ni(rst_ni), .rst_no(rst_p90_n));

  clk_int_div #(.W(DIV_W), .SYNC(SYNC_N)) u_div_prim (
    .clk_i(osc_p90_clk_i), .rst_ni(rst_p90_n), .en_i(enable_i),
    .ratio_i(core_div_i), .clk_o(prim_clk), .idle_o(prim_idle)
  );

  clk_int_div #(.W(DIV_W), .SYNC(SYNC_N)) u_div_user (
    .clk_i(osc_p0_clk_i), .rst_ni(rst_p0_n), .en_i(enable_i),
    .ratio_i(user_div_i), .clk_o(user_clk_o), .idle_o(user_idle)
  );

  clk_glitch_free_mux u_mux (
    .clk_a_i(ext_clk_i), .rst_a_ni(rst_ext_n),
    .clk_b_i(prim_clk),  .rst_b_ni(rst_p90_n),
    .sel_b_i(~bypass_i), .b_idle_i(prim_idle),
    .clk_o(core_clk_o)
  );

  AST_USER_IDLE_LOW: assert property (@(posedge osc_p0_clk_i) disable iff (!rst_p0_n)
    user_idle |-> !user_clk_o); // R7
endmodule

// File: tb/tb_clk_src_sel.sv
`timescale 1ns/1ps
module tb_clk_src_sel;
  logic rst_ni = 1'b0;
  logic ext_clk = 1'b0, osc0 = 1'b0, osc90 = 1'b0;
  logic bypass = 1'b0, enable = 1'b1;
  logic [2:0] core_div = 3'd1, user_div = 3'd1;
  logic core_clk, user_clk;

  int n_chk = 0, n_fail = 0;
  int glitch_c = 0, glitch_u = 0, edges_c = 0, edges_u = 0;
  realtime lc = -1.0, lu = -1.0;

  localparam realtime T_EXT = 4.0;
  localparam realtime T_OSC = 3.0;
  localparam realtime MIN_PULSE = 1.49;

  clk_src_sel dut (
    .rst_ni(rst_ni), .ext_clk_i(ext_clk), .osc_p0_clk_i(osc0), .osc_p90_clk_i(osc90),
    .bypass_i(bypass), .enable_i(enable), .core_div_i(core_div), .user_div_i(user_div),
    .core_clk_o(core_clk), .user_clk_o(user_clk)
  );

  always #2.0 ext_clk = ~ext_clk;
  always #1.5 osc0 = ~osc0;
  initial begin
    #0.75;
    forever #1.5 osc90 = ~osc90;
  end

  always @(core_clk) begin
    if (rst_ni) begin
      if (lc >= 0.0 && ($realtime - lc) < MIN_PULSE) glitch_c++;
      lc = $realtime;
      edges_c++;
    end else lc = -1.0;
  end

  always @(user_clk) begin
    if (rst_ni) begin
      if (lu >= 0.0 && ($realtime - lu) < MIN_PULSE) glitch_u++;
      lu = $realtime;
      edges_u++;
    end else lu = -1.0;
  end

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk_t(input string tag, input realtime act, input realtime exp);
    n_chk++;
    if (act - exp > 0.01 || exp - act > 0.01) begin
      n_fail++;
      $display("FAIL %s: got %0.3f ns expected %0.3f ns", tag, act, exp);
    end
  endtask

  task automatic chk_i(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic meas(input bit on_core, output realtime per, output realtime hi);
    realtime t0, t1, t2;
    if (on_core) begin
      @(posedge core_clk); @(posedge core_clk); t0 = $realtime;
      @(negedge core_clk); t1 = $realtime;
      @(posedge core_clk); t2 = $realtime;
    end else begin
      @(posedge user_clk); @(posedge user_clk); t0 = $realtime;
      @(negedge user_clk); t1 = $realtime;
      @(posedge user_clk); t2 = $realtime;
    end
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    realtime per, hi;
    int e_c, e_u;
    #20.3;
    chk_i("R9 core low in reset", int'(core_clk), 0);
    chk_i("R9 user low in reset", int'(user_clk), 0);
    #10.1;
    rst_ni = 1'b1;

    // R3 R4 R5: sweep of both ratios, with 0 on each side
    for (int k = 0; k < 8; k++) begin
      core_div = 3'(k);
      user_div = 3'(7 - k);
      #80.3;
      meas(1'b1, per, hi);
      chk_t((k == 0) ? "R5 core period" : "R3 core period", per, T_OSC * eff(k));
      chk_t((k == 0) ? "R5 core high"   : "R3 core high",   hi,  T_OSC * eff(k) / 2.0);
      meas(1'b0, per, hi);
      chk_t((k == 7) ? "R5 user period" : "R4 user period", per, T_OSC * eff(7 - k));
      chk_t((k == 7) ? "R5 user high"   : "R4 user high",   hi,  T_OSC * eff(7 - k) / 2.0);
    end

    // R1: switch to the external clock
    core_div = 3'd5;
    bypass = 1'b1;
    #100.3;
    meas(1'b1, per, hi);
    chk_t("R1 core period on ext", per, T_EXT);
    chk_t("R1 core high on ext", hi, T_EXT / 2.0);

    // R2: back to the oscillator path
    bypass = 1'b0;
    #100.3;
    meas(1'b1, per, hi);
    chk_t("R2 core period after return", per, T_OSC * 5);

    // R7: stop
    enable = 1'b0;
    #100.3;
    e_c = edges_c;
    e_u = edges_u;
    #100.0;
    chk_i("R7 core edges while stopped", edges_c - e_c, 0);
    chk_i("R7 user edges while stopped", edges_u - e_u, 0);
    chk_i("R7 core level while stopped", int'(core_clk), 0);
    chk_i("R7 user level while stopped", int'(user_clk), 0);

    // R8: bypass while stopped
    bypass = 1'b1;
    #100.3;
    meas(1'b1, per, hi);
    chk_t("R8 core period on ext while stopped", per, T_EXT);

    // R7: restart
    enable = 1'b1;
    bypass = 1'b0;
    user_div = 3'd3;
    #120.3;
    meas(1'b1, per, hi);
    chk_t("R7 core period after restart", per, T_OSC * 5);
    meas(1'b0, per, hi);
    chk_t("R7 user period after restart", per, T_OSC * 3);
    chk_t("R7 user high after restart", hi, T_OSC * 1.5);

    chk_i("R2 R6 short pulses on core", glitch_c, 0);
    chk_i("R6 short pulses on user", glitch_u, 0);
    finish_run();
  end
endmodule